// File: doc/BRIEF.md
# Channel-Addressed Circular Sample Store

This block sits behind a byte-wide link deserializer. It collects each group of four link bytes into a frame made of a 16-bit control word and a 16-bit data word. Sample frames are written into an external dual-port memory. The memory address is formed from the current block index and the channel number that the frame itself carries. The host reads that memory through the memory's second port. The block index moves forward whenever the last channel of a 64-channel block is stored. It wraps after a parameterised number of blocks, which by default gives one second of history at 10 kHz. Older data is therefore overwritten in a ring.

The host sees the live block index on a port, so it can tell which region is being filled. A level interrupt is raised after a programmable number of completed blocks, 16 after reset, and it stays high until the host writes to an acknowledge location. Frames that carry register traffic update a small register file that the host can read at any time. Frames of unknown kind, and frames whose target field is out of range, are discarded.

Top module: `sstore_top`

## Requirements
- R1: Link bytes accepted with `lnk_vld` form a frame in this order: control high byte, control low byte, data high byte, data low byte. A stored sample appears as `mem_we` high on the first rising edge after the edge that accepts the fourth byte. Idle cycles between bytes are allowed.
- R2: A byte accepted with `lnk_sync` high is always treated as the control high byte. Any partly collected frame is dropped.
- R3: Control bits [15:14] give the frame kind: 00 is sample, 01 is register write, 10 and 11 are reserved. Bits [13:0] form the target field. A sample frame writes its data word to `mem_waddr = {blk_ptr, target[5:0]}`.
- R4: `blk_ptr` advances by one only when a sample for channel 63 is stored, and it wraps from NUM_BLOCKS-1 to 0. Channels that arrive out of order, or are missing, are still written at their own addresses and never move the pointer.
- R5: After a synchronous reset (`rst_n` low on a clock edge) these hold: `mem_we`=0, `blk_ptr`=0, `irq`=0, all register-file entries are 0, and the block threshold is 16.
- R6: `irq` rises on the rising edge that follows the `mem_we` of the channel-63 sample completing the Nth block since the last raise, where N is the threshold. A host write with `host_wsel`=0 sets the threshold to `host_wdata`, and a threshold of 0 behaves as 1.
- R7: A host write with `host_wsel`=1 clears `irq`. If the clear falls in the same cycle as a new raise, the raise wins.
- R8: A register-write frame whose target is below NREGS stores its data word in entry `target`. This happens on the same edge that a sample would reach memory. `host_rdata` shows the entry selected by `host_raddr` without a clock delay. Such frames never write memory.
- R9: Reserved-kind frames, sample frames whose target is 64 or more, and register frames whose target is NREGS or more change no memory, pointer, interrupt or register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lnk_vld | input | 1 | A link byte is present this cycle |
| lnk_byte | input | 8 | Link byte |
| lnk_sync | input | 1 | Present byte starts a frame |
| mem_we | output | 1 | Sample memory write strobe |
| mem_waddr | output | BLK_W+6 | Sample memory address {block, channel} |
| mem_wdata | output | 16 | Sample word |
| blk_ptr | output | BLK_W | Block currently being filled |
| irq | output | 1 | Block-coalescing interrupt, level |
| host_wr | input | 1 | Host write strobe |
| host_wsel | input | 1 | 0 = threshold, 1 = interrupt acknowledge |
| host_wdata | input | 16 | Host write data |
| host_raddr | input | RA_W | Register-file read index |
| host_rdata | output | 16 | Register-file read data |

## Verification
Two functions can fall in the same cycle: the interrupt being raised by a completed block, and the host acknowledge that clears it. The bench provokes this by holding the acknowledge write active across the whole channel-63 frame that completes a threshold count, plus a few cycles after it. The reference model requires `irq` to go high on the raising edge and to fall only on the next edge. A threshold write landing in the same cycle as a block completion is also judged: the old threshold must decide that completion.

// File: rtl/sstore_pkg.sv
`timescale 1ns/1ps
// Shared frame types for the sample store.
// Assumes a 16-bit control word whose top two bits give the frame kind.
package sstore_pkg;
    localparam int WORD_W = 16;
    localparam int TGT_W  = 14;

    typedef enum logic [1:0] {
        FK_SAMPLE = 2'b00,
        FK_REGWR  = 2'b01,
        FK_RSV_A  = 2'b10,
        FK_RSV_B  = 2'b11
    } fkind_e;

    typedef struct packed {
        fkind_e             kind;
        logic [TGT_W-1:0]   tgt;
        logic [WORD_W-1:0]  data;
    } frame_t;
endpackage

// File: rtl/sstore_frame_asm.sv
`timescale 1ns/1ps
// Collects four link bytes into one frame (control high, control low,
// data high, data low). Assumes at most one byte per cycle; a sync byte
// restarts collection at the control high position.
module sstore_frame_asm
    import sstore_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    input  logic        byte_sync,
    output logic        frm_vld,
    output frame_t      frm
);
    logic [1:0] idx;
    logic [1:0] pos;
    logic [7:0] b0, b1, b2;

    // Slot that the present byte fills.
    assign pos = byte_sync ? 2'd0 : idx;

    // Byte collection and frame emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= 2'd0;
            b0      <= '0;
            b1      <= '0;
            b2      <= '0;
            frm_vld <= 1'b0;
            frm     <= '0;
        end else begin
            frm_vld <= 1'b0;
            if (byte_vld) begin
                idx <= pos + 2'd1;
                case (pos)
                    2'd0: b0 <= byte_in;
                    2'd1: b1 <= byte_in;
                    2'd2: b2 <= byte_in;
                    default: begin
                        frm     <= frame_t'({b0, b1, b2, byte_in});
                        frm_vld <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R1
    frame_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> $past(byte_vld));
endmodule

// File: rtl/sstore_sample_wr.sv
`timescale 1ns/1ps
// Turns sample frames into memory writes at {block, channel} and keeps
// the circular block index. Assumes CHANNELS is a power of two and
// NUM_BLOCKS is at least 2.
module sstore_sample_wr
    import sstore_pkg::*;
#(
    parameter int NUM_BLOCKS = 10000,
    parameter int CHANNELS   = 64,
    localparam int CH_W      = $clog2(CHANNELS),
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frm_vld,
    input  frame_t                frm,
    output logic                  mem_we,
    output logic [BLK_W+CH_W-1:0] mem_waddr,
    output logic [WORD_W-1:0]     mem_wdata,
    output logic [BLK_W-1:0]      blk_ptr,
    output logic                  blk_done
);
    logic            in_range;
    logic            take;
    logic            last_ch;
    logic [CH_W-1:0] ch;

    // Decode the frame: kind, channel range and last-channel marker.
    assign ch       = frm.tgt[CH_W-1:0];
    assign in_range = (frm.tgt[TGT_W-1:CH_W] == '0);
    assign take     = frm_vld && (frm.kind == FK_SAMPLE) && in_range;
    assign last_ch  = (ch == CH_W'(CHANNELS - 1));

    // Memory write issue and block index advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
            blk_ptr   <= '0;
            blk_done  <= 1'b0;
        end else begin
            mem_we   <= take;
            blk_done <= take && last_ch;
            if (take) begin
                mem_waddr <= {blk_ptr, ch};
                mem_wdata <= frm.data;
                if (last_ch)
                    blk_ptr <= (blk_ptr == BLK_W'(NUM_BLOCKS - 1)) ? '0 : blk_ptr + 1'b1;
            end
        end
    end

    // R3
    write_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(frm_vld));
    // R4
    ptr_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blk_ptr) |-> blk_done);
    // R4
    ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(blk_ptr) < NUM_BLOCKS);
endmodule

// File: rtl/sstore_irq_coal.sv
`timescale 1ns/1ps
// Counts completed blocks and raises a level interrupt every THRESH of
// them; a host acknowledge clears it, and a raise in the same cycle wins.
// Assumes blk_done is a single-cycle pulse.
module sstore_irq_coal #(
    parameter int CNT_W       = 16,
    parameter int IRQ_DEFAULT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_done,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wdata,
    input  logic             ack,
    output logic             irq
);
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thr_eff;
    logic             reach;

    // Zero threshold means every block.
    assign thr_eff = (thr == '0) ? CNT_W'(1) : thr;
    assign reach   = ((CNT_W+1)'(cnt) + 1'b1) >= (CNT_W+1)'(thr_eff);

    // Threshold register, block counter and interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= CNT_W'(IRQ_DEFAULT);
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            if (thr_we)
                thr <= thr_wdata;
            if (blk_done && reach) begin
                irq <= 1'b1;
                cnt <= '0;
            end else begin
                if (blk_done)
                    cnt <= cnt + 1'b1;
                if (ack)
                    irq <= 1'b0;
            end
        end
    end

    // R6
    irq_rise_on_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(blk_done));
    // R7
    irq_fall_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(ack));
endmodule

// File: rtl/sstore_reg_file.sv
`timescale 1ns/1ps
// Small register file written by register-write frames and read by the
// host without latency. Assumes NREGS is a power of two.
module sstore_reg_file
    import sstore_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int RA_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_vld,
    input  frame_t            frm,
    input  logic [RA_W-1:0]   raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] regs [NREGS];
    logic              wr;

    // Accept only register frames aimed inside the file.
    assign wr = frm_vld && (frm.kind == FK_REGWR) && (frm.tgt[TGT_W-1:RA_W] == '0);

    // Per-entry update.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr && (frm.tgt[RA_W-1:0] == RA_W'(i)))
                regs[i] <= frm.data;
        end
    end

    // Host read path.
    assign rdata = regs[raddr];

    // R8
    reg_read_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(rdata));
endmodule

// File: rtl/sstore_top.sv
`timescale 1ns/1ps
// Channel-addressed circular sample store: link frames in, sample memory
// writes, block pointer, coalesced interrupt and a register file out.
// Assumes an external dual-port memory whose second port serves the host.
module sstore_top
    import sstore_pkg::*;
#(
    parameter int NUM_BLOCKS  = 10000,
    parameter int CHANNELS    = 64,
    parameter int NREGS       = 8,
    parameter int IRQ_DEFAULT = 16,
    localparam int BLK_W      = $clog2(NUM_BLOCKS),
    localparam int CH_W       = $clog2(CHANNELS),
    localparam int RA_W       = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lnk_vld,
    input  logic [7:0]            lnk_byte,
    input  logic                  lnk_sync,
    output logic                  mem_we,
    output logic [BLK_W+CH_W-1:0] mem_waddr,
    output logic [WORD_W-1:0]     mem_wdata,
    output logic [BLK_W-1:0]      blk_ptr,
    output logic                  irq,
    input  logic                  host_wr,
    input  logic                  host_wsel,
    input  logic [WORD_W-1:0]     host_wdata,
    input  logic [RA_W-1:0]       host_raddr,
    output logic [WORD_W-1:0]     host_rdata
);
    logic   frm_vld;
    frame_t frm;
    logic   blk_done;

    sstore_frame_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (lnk_vld),
        .byte_in   (lnk_byte),
        .byte_sync (lnk_sync),
        .frm_vld   (frm_vld),
        .frm       (frm)
    );

    sstore_sample_wr #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .CHANNELS   (CHANNELS)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_vld   (frm_vld),
        .frm       (frm),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .blk_ptr   (blk_ptr),
        .blk_done  (blk_done)
    );

    sstore_irq_coal #(
        .CNT_W       (WORD_W),
        .IRQ_DEFAULT (IRQ_DEFAULT)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_done  (blk_done),
        .thr_we    (host_wr && !host_wsel),
        .thr_wdata (host_wdata),
        .ack       (host_wr && host_wsel),
        .irq       (irq)
    );

    sstore_reg_file #(
        .NREGS (NREGS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .frm_vld (frm_vld),
        .frm     (frm),
        .raddr   (host_raddr),
        .rdata   (host_rdata)
    );
endmodule

// File: tb/sstore_top_tb.sv
`timescale 1ns/1ps
module sstore_top_tb;
    localparam int NB = 5;
    localparam int NR = 8;
    localparam int BW = $clog2(NB);
    localparam int AW = BW + 6;
    localparam int RW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lnk_vld = 1'b0;
    logic [7:0]    lnk_byte = '0;
    logic          lnk_sync = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [15:0]   mem_wdata;
    logic [BW-1:0] blk_ptr;
    logic          irq;
    logic          host_wr = 1'b0;
    logic          host_wsel = 1'b0;
    logic [15:0]   host_wdata = '0;
    logic [RW-1:0] host_raddr = '0;
    logic [15:0]   host_rdata;

    always #2.5 clk = ~clk;

    sstore_top #(.NUM_BLOCKS(NB), .NREGS(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .lnk_vld(lnk_vld), .lnk_byte(lnk_byte),
        .lnk_sync(lnk_sync), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .blk_ptr(blk_ptr), .irq(irq),
        .host_wr(host_wr), .host_wsel(host_wsel), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit fin = 1'b0;
    bit use_gaps = 1'b0;

    // Behavioural reference state.
    int m_idx, m_bytes[4], m_fvld, m_fctrl, m_fdata;
    int m_we, m_addr, m_wdata, m_ptr, m_done;
    int m_cnt, m_thr, m_irq, m_regs[NR];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // Reference model, one step per rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_idx = 0; m_fvld = 0; m_fctrl = 0; m_fdata = 0;
            m_we = 0; m_addr = 0; m_wdata = 0; m_ptr = 0; m_done = 0;
            m_cnt = 0; m_thr = 16; m_irq = 0;
            foreach (m_regs[i]) m_regs[i] = 0;
        end else begin
            int te, kind, tgt, p;
            te = (m_thr == 0) ? 1 : m_thr;
            if (m_done != 0) begin
                if (m_cnt + 1 >= te) begin m_irq = 1; m_cnt = 0; end
                else begin m_cnt++; if (host_wr && host_wsel) m_irq = 0; end
            end else if (host_wr && host_wsel) m_irq = 0;
            if (host_wr && !host_wsel) m_thr = int'(host_wdata);
            m_we = 0; m_done = 0;
            if (m_fvld != 0) begin
                kind = (m_fctrl >> 14) & 3;
                tgt  = m_fctrl & 16'h3fff;
                if (kind == 0 && tgt < 64) begin
                    m_we = 1; m_addr = m_ptr * 64 + tgt; m_wdata = m_fdata;
                    if (tgt == 63) begin m_ptr = (m_ptr + 1) % NB; m_done = 1; end
                end else if (kind == 1 && tgt < NR) m_regs[tgt] = m_fdata;
            end
            m_fvld = 0;
            if (lnk_vld) begin
                p = lnk_sync ? 0 : m_idx;
                m_bytes[p] = int'(lnk_byte);
                if (p == 3) begin
                    m_fvld = 1;
                    m_fctrl = m_bytes[0] * 256 + m_bytes[1];
                    m_fdata = m_bytes[2] * 256 + m_bytes[3];
                end
                m_idx = (p + 1) % 4;
            end
        end
    end

    // Compare outputs against the model after every edge.
    always @(posedge clk) begin
        #1;
        if (!fin) begin
            chk("R1/R2/R3/R5/R8/R9 mem_we", 32'(mem_we), 32'(m_we));
            if (m_we != 0) begin
                chk("R3/R4 mem_waddr", 32'(mem_waddr), 32'(m_addr));
                chk("R1/R3 mem_wdata", 32'(mem_wdata), 32'(m_wdata));
            end
            chk("R4/R5/R9 blk_ptr", 32'(blk_ptr), 32'(m_ptr));
            chk("R6/R7/R5 irq", 32'(irq), 32'(m_irq));
            chk("R8/R9/R5 host_rdata", 32'(host_rdata), 32'(m_regs[host_raddr]));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 100000 && !fin) begin
            fin = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            lnk_vld = 1'b0; lnk_sync = 1'b0;
            host_raddr = RW'($urandom % NR);
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input int ctrl, input int data, input bit sync_first);
        for (int i = 0; i < 4; i++) begin
            if (use_gaps && ($urandom % 4 == 0)) idle(1);
            lnk_vld  = 1'b1;
            lnk_sync = (i == 0) && sync_first;
            case (i)
                0: lnk_byte = 8'(ctrl >> 8);
                1: lnk_byte = 8'(ctrl);
                2: lnk_byte = 8'(data >> 8);
                default: lnk_byte = 8'(data);
            endcase
            host_raddr = RW'($urandom % NR);
            @(negedge clk);
        end
        lnk_vld = 1'b0; lnk_sync = 1'b0;
    endtask

    task automatic send_partial(input int n);
        for (int i = 0; i < n; i++) begin
            lnk_vld = 1'b1; lnk_sync = 1'b0; lnk_byte = 8'($urandom);
            @(negedge clk);
        end
        lnk_vld = 1'b0;
    endtask

    task automatic host_write(input bit sel, input int data);
        host_wr = 1'b1; host_wsel = sel; host_wdata = 16'(data);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R5: reset state is compared by the per-cycle checks above.
        rst_n = 1'b1;
        idle(2);

        // Default threshold of 16, in-order blocks, pointer wraps (R4, R6).
        for (int b = 0; b < 16; b++)
            for (int ch = 0; ch < 64; ch++)
                send_frame(ch, int'($urandom % 65536), 1'b0);
        idle(4);
        host_write(1'b1, 0);

        // Threshold 2, gaps, register and discarded frames, ack/raise collision (R7, R8, R9).
        host_write(1'b0, 2);
        use_gaps = 1'b1;
        for (int b = 0; b < 4; b++)
            for (int ch = 0; ch < 64; ch++) begin
                if ($urandom % 8 == 0)
                    send_frame((1 << 14) | int'($urandom % 10), int'($urandom % 65536), 1'b0);
                if ($urandom % 10 == 0)
                    send_frame(((2 + int'($urandom % 2)) << 14) | 63, int'($urandom % 65536), 1'b0);
                if ($urandom % 12 == 0)
                    send_frame(64 | 63, int'($urandom % 65536), 1'b0);
                if (ch == 63 && (b % 2 == 1)) begin
                    host_wr = 1'b1; host_wsel = 1'b1;
                    send_frame(ch, int'($urandom % 65536), 1'b0);
                    idle(4);
                    host_wr = 1'b0;
                end else
                    send_frame(ch, int'($urandom % 65536), 1'b0);
            end
        idle(3);

        // Threshold 0 acts as 1; random channels, aborted frames with resync (R2, R4, R6).
        host_write(1'b0, 0);
        for (int k = 0; k < 300; k++) begin
            bit sy;
            sy = ($urandom % 3 == 0);
            if (sy && ($urandom % 2 == 0)) send_partial(1 + int'($urandom % 3));
            if ($urandom % 16 == 0) host_write(1'b1, 0);
            send_frame(int'($urandom % 64), int'($urandom % 65536), sy);
        end
        idle(6);

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule